// File: doc/BRIEF.md
# Periodic frame list walker

This block is the front end of the periodic schedule in a USB host controller. It holds a free-running microframe index, and it builds the byte address of the current frame-list entry from a base register and that index. The base register is aligned to a 4 KB page. The list length is selectable, and the slot taken from the index is masked to that length, so the list behaves as a window that wraps back to entry 0.

On every frame start tick the block reads the entry through a simple request/acknowledge memory port. It then follows the chain of link pointers. It passes each pointer that has its terminate bit clear, together with its type, to a downstream transaction engine. The walk stops at a pointer whose terminate bit is set.

A run enable gates all activity. If a tick arrives before the chain has ended, the walk is dropped, a one-cycle overrun flag is raised, and the entry for the new frame is fetched. A queue head that several list entries point to is revisited each time it is reached; no state is kept about earlier visits.

Top module: `pfl_walker`

## Requirements
- R1: After reset `frame_idx` is 0, and `rd_req`, `item_valid` and `overrun` are low.
- R2: `frame_idx` rises by exactly 1 on each cycle in which `frame_tick` and `run_en` are both high. It wraps from 16383 to 0 and holds its value otherwise.
- R3: A tick while running and not walking raises `rd_req` in the next cycle. The request address is `{base_hi, 12'h000} | (slot << 2)`, where slot is `frame_idx[13:3]` (the value at the tick) masked to log2(length) bits.
- R4: The length is set by `size_ext` and `size_sel`. With `size_ext`=0, codes 0, 1, 2 and 3 give 1024, 512, 256 and 8 entries. With `size_ext`=1, codes 0, 1, 2 and 3 give 128, 64, 32 and 16 entries. Slots past the length wrap to entry 0.
- R5: While `rd_req` is high and `rd_ack` is low, `rd_req` stays high in the next cycle and `rd_addr` does not change.
- R6: A response (`rd_ack` high with `rd_req`) whose bit 0 is 0 causes a one-cycle `item_valid` in the next cycle. In that cycle `item_addr` is `rd_data` with bits [4:0] cleared, and `item_type` is `rd_data[2:1]` (0 isochronous TD, 1 queue head, 2 split isochronous TD, 3 frame span node). A read of `item_addr` is requested in the same cycle.
- R7: A response with bit 0 equal to 1 ends the walk: in the next cycle `rd_req` and `item_valid` are low.
- R8: A tick while running during a walk raises `overrun` for one cycle in the next cycle. If a response arrives in that same cycle, its data is discarded: no item is produced, and the next request goes to the entry of the new tick's index.
- R9: A tick during a walk while a read is still unacknowledged leaves that request as it is. When the response arrives, its data is discarded and the new frame's entry is requested next.
- R10: With `run_en` low, ticks are ignored: the index does not move and no overrun is raised. A pending read still completes, its data is discarded, and the block then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run/stop enable |
| frame_tick | input | 1 | One-cycle microframe start pulse |
| base_hi | input | 20 | Frame list base address bits [31:12] |
| size_ext | input | 1 | Length code extension bit |
| size_sel | input | 2 | Length code field |
| rd_req | output | 1 | Memory read request, held until acknowledged |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read response strobe, carries data |
| rd_data | input | 32 | Read response word |
| item_valid | output | 1 | One-cycle strobe for a live link pointer |
| item_addr | output | 32 | Pointer target, 32-byte aligned |
| item_type | output | 2 | Pointer type |
| overrun | output | 1 | One-cycle flag: walk cut short by a new tick |
| frame_idx | output | 14 | Current microframe index |

## Verification
Two functions can fall in the same cycle: the frame tick that starts a new walk, and the read response that would extend the current one. The bench provokes this by asserting `frame_tick` and `rd_ack` on the same edge, with a non-terminal link word and an index whose low three bits are 7, so that the new entry address differs from the old one. The result is judged correct when `overrun` pulses, no item appears, and the next request carries the new frame's entry address. The same collision is also run with the response arriving later, and with the run enable dropped while a read is in flight.

// File: rtl/pfl_pkg.sv
// Shared types and the list length decode for the periodic frame list walker.
// Assumes the 3-bit size code is static while a fetch address is being formed.
package pfl_pkg;

    typedef enum logic [1:0] {
        LK_ITD  = 2'd0,
        LK_QH   = 2'd1,
        LK_SITD = 2'd2,
        LK_FSTN = 2'd3
    } link_kind_e;

    typedef enum logic {
        WK_IDLE  = 1'b0,
        WK_FETCH = 1'b1
    } walk_state_e;

    // Returns log2 of the list length selected by the extension bit and field.
    function automatic logic [3:0] list_log2(input logic ext, input logic [1:0] sel);
        logic [3:0] lg;
        if (!ext) begin
            case (sel)
                2'd0:    lg = 4'd10;
                2'd1:    lg = 4'd9;
                2'd2:    lg = 4'd8;
                default: lg = 4'd3;
            endcase
        end else begin
            case (sel)
                2'd0:    lg = 4'd7;
                2'd1:    lg = 4'd6;
                2'd2:    lg = 4'd5;
                default: lg = 4'd4;
            endcase
        end
        return lg;
    endfunction

endpackage

// File: rtl/pfl_index.sv
// Free-running microframe index.
// Advances by one on each qualified tick and wraps at 2**IDX_W.
// Assumes adv is already gated by the run enable.
module pfl_index #(
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);

    // Count qualified ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) idx <= '0;
        else if (adv) idx <= idx + 1'b1;
    end

    assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> idx == $past(idx) + 1'b1);

    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx));

endmodule

// File: rtl/pfl_addr.sv
// Forms the byte address of the current frame list entry.
// The base is page aligned. The slot is the index with its microframe bits dropped,
// masked to the selected length, and scaled to 4-byte entries.
module pfl_addr
    import pfl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 14,
    parameter int PAGE_W = 12
) (
    input  logic [ADDR_W-PAGE_W-1:0] base_hi,
    input  logic                     size_ext,
    input  logic [1:0]               size_sel,
    input  logic [IDX_W-1:0]         idx,
    output logic [ADDR_W-1:0]        elem_addr
);

    localparam int UFRAME_BITS = 3;
    localparam int ENTRY_SHIFT = 2;

    logic [3:0]       len_log;
    logic [IDX_W-1:0] slot_full;
    logic [IDX_W-1:0] slot_mask;
    logic [IDX_W-1:0] slot;

    // Decode the length and combine the base with the masked slot.
    always_comb begin
        len_log   = list_log2(size_ext, size_sel);
        slot_full = idx >> UFRAME_BITS;
        slot_mask = (IDX_W'(1) << len_log) - IDX_W'(1);
        slot      = slot_full & slot_mask;
        elem_addr = {base_hi, {PAGE_W{1'b0}}} | (ADDR_W'(slot) << ENTRY_SHIFT);
    end

endmodule

// File: rtl/pfl_walk.sv
// Link pointer walker.
// Fetches the frame entry on each tick and follows live pointers until a terminator.
// Drops a walk when a new tick arrives. The memory port holds each request until it
// is acknowledged, and read data arrives with the acknowledge.
module pfl_walk
    import pfl_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tick_go,
    input  logic [ADDR_W-1:0] elem_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [ADDR_W-1:0] rd_data,
    output logic              item_valid,
    output logic [ADDR_W-1:0] item_addr,
    output logic [1:0]        item_type,
    output logic              overrun
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_W) - ADDR_W'(1));

    walk_state_e       st;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] pend_q;
    logic              restart_q;
    logic [ADDR_W-1:0] link_addr;
    logic              link_term;
    link_kind_e        link_kind;

    // Split the returned link word into its fields.
    always_comb begin
        link_addr = rd_data & ALIGN_MASK;
        link_term = rd_data[0];
        link_kind = link_kind_e'(rd_data[2:1]);
    end

    assign rd_req  = (st == WK_FETCH);
    assign rd_addr = addr_q;

    // Walk state, fetch address and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= WK_IDLE;
            addr_q     <= '0;
            pend_q     <= '0;
            restart_q  <= 1'b0;
            item_valid <= 1'b0;
            item_addr  <= '0;
            item_type  <= LK_ITD;
            overrun    <= 1'b0;
        end else begin
            item_valid <= 1'b0;
            overrun    <= 1'b0;
            case (st)
                WK_IDLE: begin
                    if (tick_go) begin
                        addr_q <= elem_addr;
                        st     <= WK_FETCH;
                    end
                end
                default: begin
                    if (tick_go) begin
                        overrun <= 1'b1;
                        if (rd_ack) begin
                            addr_q    <= elem_addr;
                            restart_q <= 1'b0;
                        end else begin
                            pend_q    <= elem_addr;
                            restart_q <= 1'b1;
                        end
                    end else if (rd_ack) begin
                        if (!run_en) begin
                            st        <= WK_IDLE;
                            restart_q <= 1'b0;
                        end else if (restart_q) begin
                            addr_q    <= pend_q;
                            restart_q <= 1'b0;
                        end else if (link_term) begin
                            st <= WK_IDLE;
                        end else begin
                            item_valid <= 1'b1;
                            item_addr  <= link_addr;
                            item_type  <= link_kind;
                            addr_q     <= link_addr;
                        end
                    end
                end
            endcase
        end
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_item_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        item_valid |-> (rd_req && rd_addr == item_addr));

    assert_term_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && link_term && run_en && !tick_go && !restart_q)
        |=> (!rd_req && !item_valid));

    assert_no_item_on_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !item_valid);

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && !run_en) |=> (!rd_req && !item_valid));

endmodule

// File: rtl/pfl_walker.sv
// Periodic frame list walker top.
// Ties the microframe index, entry address former and link walker together.
// Assumes frame_tick is a one-cycle pulse and the size code is stable around ticks.
module pfl_walker
    import pfl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 14,
    parameter int PAGE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic                     frame_tick,
    input  logic [ADDR_W-PAGE_W-1:0] base_hi,
    input  logic                     size_ext,
    input  logic [1:0]               size_sel,
    output logic                     rd_req,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_ack,
    input  logic [ADDR_W-1:0]        rd_data,
    output logic                     item_valid,
    output logic [ADDR_W-1:0]        item_addr,
    output logic [1:0]               item_type,
    output logic                     overrun,
    output logic [IDX_W-1:0]         frame_idx
);

    logic              tick_go;
    logic [ADDR_W-1:0] elem_addr;

    // Qualify the frame tick with the run enable.
    assign tick_go = frame_tick & run_en;

    pfl_index #(.IDX_W(IDX_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tick_go),
        .idx   (frame_idx)
    );

    pfl_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_addr (
        .base_hi   (base_hi),
        .size_ext  (size_ext),
        .size_sel  (size_sel),
        .idx       (frame_idx),
        .elem_addr (elem_addr)
    );

    pfl_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .tick_go    (tick_go),
        .elem_addr  (elem_addr),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .item_valid (item_valid),
        .item_addr  (item_addr),
        .item_type  (item_type),
        .overrun    (overrun)
    );

    assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !rd_req) |=> (!rd_req && !overrun));

endmodule

// File: tb/sim_pfl_walker.sv
// Self-checking bench for the periodic frame list walker.
module sim_pfl_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        frame_tick = 1'b0;
    logic [19:0] base_hi = 20'hABCDE;
    logic        size_ext = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = 32'd0;
    logic        item_valid;
    logic [31:0] item_addr;
    logic [1:0]  item_type;
    logic        overrun;
    logic [13:0] frame_idx;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [13:0] cur_idx = 14'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfl_walker u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .frame_tick(frame_tick),
        .base_hi(base_hi), .size_ext(size_ext), .size_sel(size_sel),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .item_valid(item_valid), .item_addr(item_addr), .item_type(item_type),
        .overrun(overrun), .frame_idx(frame_idx)
    );

    // Table: {size_ext, size_sel, index at tick, expected entry address}
    localparam logic [48:0] VEC [17] = '{
        {1'b0, 2'd0, 14'h0000, 32'hABCDE000},
        {1'b0, 2'd0, 14'h0008, 32'hABCDE004},
        {1'b1, 2'd2, 14'h00F8, 32'hABCDE07C},
        {1'b1, 2'd2, 14'h0100, 32'hABCDE000},
        {1'b1, 2'd3, 14'h0108, 32'hABCDE004},
        {1'b0, 2'd3, 14'h0140, 32'hABCDE000},
        {1'b0, 2'd3, 14'h0148, 32'hABCDE004},
        {1'b1, 2'd0, 14'h03F8, 32'hABCDE1FC},
        {1'b1, 2'd0, 14'h0400, 32'hABCDE000},
        {1'b1, 2'd1, 14'h0408, 32'hABCDE004},
        {1'b0, 2'd2, 14'h07F8, 32'hABCDE3FC},
        {1'b0, 2'd1, 14'h0FF8, 32'hABCDE7FC},
        {1'b0, 2'd1, 14'h1000, 32'hABCDE000},
        {1'b0, 2'd0, 14'h1FF8, 32'hABCDEFFC},
        {1'b0, 2'd0, 14'h2000, 32'hABCDE000},
        {1'b0, 2'd0, 14'h3FFF, 32'hABCDEFFC},
        {1'b0, 2'd0, 14'h0000, 32'hABCDE000}
    };

    function automatic logic [31:0] exp_addr(input logic [13:0] i, input logic e,
                                             input logic [1:0] s);
        int lg;
        int slot;
        if (!e) lg = (s == 2'd0) ? 10 : (s == 2'd1) ? 9 : (s == 2'd2) ? 8 : 3;
        else    lg = (s == 2'd0) ? 7 : (s == 2'd1) ? 6 : (s == 2'd2) ? 5 : 4;
        slot = (int'(i) / 8) % (1 << lg);
        return 32'hABCDE000 + 32'(slot * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One frame: tick, optionally check the entry request, answer with a terminator.
    task automatic step(input bit do_chk, input logic [31:0] exp, input string tag);
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0; cur_idx++;
        if (do_chk) begin
            chk({tag, " rd_req"}, 32'(rd_req), 32'd1);
            chk({tag, " rd_addr"}, rd_addr, exp);
        end
        rd_ack = 1'b1; rd_data = 32'h1;
        @(negedge clk); rd_ack = 1'b0; rd_data = 32'h0;
    endtask

    task automatic align7();
        while (cur_idx[2:0] != 3'd7) step(1'b0, 32'h0, "");
    endtask

    initial begin
        logic [31:0] olda;
        logic [31:0] newa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frame_idx", 32'(frame_idx), 32'd0);
        chk("R1 rd_req", 32'(rd_req), 32'd0);
        chk("R1 item_valid", 32'(item_valid), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        run_en = 1'b1;

        // R3 / R4: table of sizes and indices, walked in index order
        for (int i = 0; i < 17; i++) begin
            if (i == 16) begin
                chk("R2 wrap frame_idx", 32'(frame_idx), 32'd0);
            end
            while (cur_idx != VEC[i][45:32]) step(1'b0, 32'h0, "");
            size_ext = VEC[i][48];
            size_sel = VEC[i][47:46];
            step(1'b1, VEC[i][31:0], $sformatf("R3 R4 vec%0d", i));
        end
        chk("R2 frame_idx", 32'(frame_idx), 32'(cur_idx));
        size_ext = 1'b0; size_sel = 2'd0;

        // R5 hold, R6 follow links, R7 terminate
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0; cur_idx++;
        olda = exp_addr(cur_idx - 14'd1, 1'b0, 2'd0);
        for (int k = 0; k < 3; k++) begin
            chk("R5 rd_req", 32'(rd_req), 32'd1);
            chk("R5 rd_addr", rd_addr, olda);
            @(negedge clk);
        end
        rd_ack = 1'b1; rd_data = 32'h12345662;
        @(negedge clk); rd_ack = 1'b0;
        chk("R6 item_valid", 32'(item_valid), 32'd1);
        chk("R6 item_addr", item_addr, 32'h12345660);
        chk("R6 item_type", 32'(item_type), 32'd1);
        chk("R6 rd_addr", rd_addr, 32'h12345660);
        rd_ack = 1'b1; rd_data = 32'h00001004;
        @(negedge clk); rd_ack = 1'b0;
        chk("R6 item_valid 2", 32'(item_valid), 32'd1);
        chk("R6 item_addr 2", item_addr, 32'h00001000);
        chk("R6 item_type 2", 32'(item_type), 32'd2);
        rd_ack = 1'b1; rd_data = 32'h00002007;
        @(negedge clk); rd_ack = 1'b0; rd_data = 32'h0;
        chk("R7 rd_req", 32'(rd_req), 32'd0);
        chk("R7 item_valid", 32'(item_valid), 32'd0);

        // R8: tick and response in the same cycle
        align7();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0; cur_idx++;
        olda = rd_addr;
        frame_tick = 1'b1; rd_ack = 1'b1; rd_data = 32'h00000040;
        @(negedge clk); frame_tick = 1'b0; rd_ack = 1'b0; rd_data = 32'h0; cur_idx++;
        newa = exp_addr(cur_idx - 14'd1, 1'b0, 2'd0);
        chk("R8 overrun", 32'(overrun), 32'd1);
        chk("R8 item_valid", 32'(item_valid), 32'd0);
        chk("R8 rd_req", 32'(rd_req), 32'd1);
        chk("R8 rd_addr", rd_addr, newa);
        chk("R8 new differs", 32'(newa != olda), 32'd1);
        @(negedge clk);
        chk("R8 overrun pulse", 32'(overrun), 32'd0);
        rd_ack = 1'b1; rd_data = 32'h1;
        @(negedge clk); rd_ack = 1'b0; rd_data = 32'h0;

        // R9: tick while the read is unacknowledged
        align7();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0; cur_idx++;
        olda = exp_addr(cur_idx - 14'd1, 1'b0, 2'd0);
        frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0; cur_idx++;
        newa = exp_addr(cur_idx - 14'd1, 1'b0, 2'd0);
        chk("R9 overrun", 32'(overrun), 32'd1);
        chk("R9 old rd_addr", rd_addr, olda);
        rd_ack = 1'b1; rd_data = 32'h00000080;
        @(negedge clk); rd_ack = 1'b0; rd_data = 32'h0;
        chk("R9 item_valid", 32'(item_valid), 32'd0);
        chk("R9 rd_req", 32'(rd_req), 32'd1);
        chk("R9 new rd_addr", rd_addr, newa);
        rd_ack = 1'b1; rd_data = 32'h1;
        @(negedge clk); rd_ack = 1'b0; rd_data = 32'h0;

        // R10: stop while a read is pending
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0; cur_idx++;
        run_en = 1'b0; frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        chk("R10 overrun", 32'(overrun), 32'd0);
        chk("R10 frame_idx", 32'(frame_idx), 32'(cur_idx));
        chk("R10 rd_req pending", 32'(rd_req), 32'd1);
        rd_ack = 1'b1; rd_data = 32'h00000100;
        @(negedge clk); rd_ack = 1'b0; rd_data = 32'h0;
        chk("R10 rd_req idle", 32'(rd_req), 32'd0);
        chk("R10 item_valid", 32'(item_valid), 32'd0);
        frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        @(negedge clk);
        chk("R10 tick ignored rd_req", 32'(rd_req), 32'd0);
        chk("R10 tick ignored frame_idx", 32'(frame_idx), 32'(cur_idx));
        run_en = 1'b1;
        step(1'b1, exp_addr(cur_idx, 1'b0, 2'd0), "R10 resume");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule